// File: doc/BRIEF.md
# Suspendable Expansion Bus Read Controller

This block is a host-side sequencer for reads from a slow external peripheral controller on a shared system bus. After the host issues the address cycle, the peripheral is allowed to take as long as it needs. Rather than holding the bus in wait states, the sequencer gives the bus up at once. A higher-priority master, such as a display refresh DMA engine, can then keep using the bus while the read is parked.

When the peripheral raises its ready input, the sequencer asks the arbiter for the bus again. Once it is granted, it asserts chip select again and moves the data over a 16-bit path. A word takes two clocks, low half first, and a byte takes one clock. The result goes back to the CPU port with a one-cycle done pulse. There is no time-out. A parked read ends only when the peripheral signals ready, and on a failed access the peripheral forces completion with whatever data it supplies. All timing follows one free-running expansion clock, which the system has to keep running.

Top module: `xbus_rd_seq`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the block returns to idle: after that edge `xb_cs_n` is 1 and `bus_req`, `xb_addr_oe` and `cpu_done` are 0.
- R2: A `cpu_req` sampled in idle raises `bus_req` on the next edge. On the edge after the grant, the block enters a one-cycle address phase with `xb_cs_n` = 0, `xb_addr_oe` = 1 and `xb_addr` equal to the captured address.
- R3: On the edge that ends the address phase, the block releases the bus: `bus_req` = 0, `xb_cs_n` = 1, `xb_addr_oe` = 0.
- R4: `xb_ready` is sampled only while the read is parked. A ready level that is seen only during the address phase has no effect, and the bus stays released.
- R5: `xb_ready` = 1 while parked raises `bus_req` on the next edge. `bus_req` then stays high, with `xb_cs_n` = 1, for as long as `bus_gnt` is 0.
- R6: On the edge after a grant for a parked read, a one-cycle resume phase drives `xb_cs_n` = 0. A word read (`cpu_byte` = 0) then takes `xb_din` on the next two clocks, the first into `cpu_rdata[15:0]` and the second into `cpu_rdata[31:16]`. `cpu_done` rises the cycle after the second transfer.
- R7: A byte read (`cpu_byte` = 1) takes a single transfer clock. It returns `xb_din[7:0]` when address bit 0 is 0 and `xb_din[15:8]` when it is 1, zero-extended to 32 bits. `cpu_done` rises the cycle after that transfer.
- R8: Chip select is low only while the block holds both `bus_req` and `bus_gnt`. `xb_addr_oe` is never 1 while `xb_cs_n` is 1.
- R9: `cpu_done` is a single-cycle pulse with `bus_req` = 0, after which the block is idle. A `cpu_req` that arrives while a read is in progress is ignored: it causes no second bus request and no change of address.
- R10: There is no time-out. A parked read stays released, with `bus_req` = 0 and `xb_cs_n` = 1, for as long as `xb_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Expansion clock, free-running |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Read request, sampled in idle |
| cpu_addr | input | AW | Read address |
| cpu_byte | input | 1 | 1 = byte read, 0 = 32-bit word read |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 2*DW | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| xb_cs_n | output | 1 | Peripheral chip select, active low |
| xb_addr | output | AW | Address bus, zero when not driven |
| xb_addr_oe | output | 1 | Address bus output enable |
| xb_ready | input | 1 | Peripheral read data ready |
| xb_din | input | DW | Read data from the peripheral |

## Verification
Every output comes straight from registered state, so each result lands a fixed number of edges after its cause. `bus_req` follows a request or a ready by one edge. Chip select follows a grant by one edge. The release follows the address phase by one edge. `cpu_done` comes two edges after the resume phase for a byte and three for a word. The bench drives inputs and samples outputs on the falling edge, and steps through a read one falling edge at a time, comparing each output in the exact cycle these counts give. It places each half of the read data on `xb_din` only in its own transfer cycle, with junk values around it, so a capture one cycle off shows up as a wrong result.

// File: rtl/xbus_rd_pkg.sv
package xbus_rd_pkg;

    localparam int XB_AW = 24;
    localparam int XB_DW = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUSPEND,
        ST_REQ_BUS,
        ST_RESUME,
        ST_XFER0,
        ST_XFER1,
        ST_DONE
    } xrd_state_e;

    typedef struct packed {
        logic cs;      // chip select asserted (bus owned)
        logic breq;    // request / hold the system bus
        logic cap_lo;  // first (or only) data capture
        logic cap_hi;  // second data capture of a word
        logic done;    // completion pulse to CPU
    } xrd_ctl_t;

    function automatic int lane_bits(input int dw);
        return (dw / 8 > 1) ? $clog2(dw / 8) : 1;
    endfunction

    function automatic xrd_ctl_t decode_ctl(input xrd_state_e st);
        xrd_ctl_t c;
        c = '0;
        unique case (st)
            ST_ADDR:    begin c.cs = 1'b1; c.breq = 1'b1; end
            ST_REQ_BUS: c.breq = 1'b1;
            ST_RESUME:  begin c.cs = 1'b1; c.breq = 1'b1; end
            ST_XFER0:   begin c.cs = 1'b1; c.breq = 1'b1; c.cap_lo = 1'b1; end
            ST_XFER1:   begin c.cs = 1'b1; c.breq = 1'b1; c.cap_hi = 1'b1; end
            ST_DONE:    c.done = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xbus_rd_fsm.sv
module xbus_rd_fsm
    import xbus_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_req,
    input  logic       byte_mode,
    input  logic       bus_gnt,
    input  logic       xb_ready,
    output logic       idle,
    output xrd_ctl_t   ctl
);

    xrd_state_e state_q, state_d;
    logic       resumed_q, resumed_d;

    always_comb begin
        state_d   = state_q;
        resumed_d = resumed_q;
        unique case (state_q)
            ST_IDLE: if (cpu_req) begin
                state_d   = ST_REQ_BUS;
                resumed_d = 1'b0;
            end
            ST_REQ_BUS: if (bus_gnt) begin
                state_d = resumed_q ? ST_RESUME : ST_ADDR;
            end
            ST_ADDR: begin
                state_d   = ST_SUSPEND;
                resumed_d = 1'b1;
            end
            ST_SUSPEND: if (xb_ready) state_d = ST_REQ_BUS;
            ST_RESUME:  state_d = ST_XFER0;
            ST_XFER0:   state_d = byte_mode ? ST_DONE : ST_XFER1;
            ST_XFER1:   state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            resumed_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            resumed_q <= resumed_d;
        end
    end

    assign idle = (state_q == ST_IDLE);
    assign ctl  = decode_ctl(state_q);

endmodule

// File: rtl/xbus_rd_capture.sv
module xbus_rd_capture #(
    parameter int DW = xbus_rd_pkg::XB_DW,
    localparam int WW = 2 * DW,
    localparam int LANES = DW / 8,
    localparam int LB = xbus_rd_pkg::lane_bits(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_mode,
    input  logic [LB-1:0] lane_sel,
    input  logic          cap_lo,
    input  logic          cap_hi,
    input  logic [DW-1:0] din,
    output logic [WW-1:0] rdata
);

    logic [7:0] lane_w [LANES];
    logic [7:0] byte_val;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_w[g] = din[g*8 +: 8];
    end

    assign byte_val = lane_w[lane_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (cap_lo) begin
            if (byte_mode) rdata <= {{(WW-8){1'b0}}, byte_val};
            else           rdata <= {{DW{1'b0}}, din};
        end else if (cap_hi) begin
            rdata[WW-1:DW] <= din;
        end
    end

endmodule

// File: rtl/xbus_rd_seq.sv
module xbus_rd_seq
    import xbus_rd_pkg::*;
#(
    parameter int AW = XB_AW,
    parameter int DW = XB_DW,
    localparam int WW = 2 * DW,
    localparam int LB = lane_bits(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_byte,
    output logic          cpu_done,
    output logic [WW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          xb_cs_n,
    output logic [AW-1:0] xb_addr,
    output logic          xb_addr_oe,
    input  logic          xb_ready,
    input  logic [DW-1:0] xb_din
);

    logic          idle;
    xrd_ctl_t      ctl;
    logic [AW-1:0] addr_q;
    logic          byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            byte_q <= 1'b0;
        end else if (idle && cpu_req) begin
            addr_q <= cpu_addr;
            byte_q <= cpu_byte;
        end
    end

    xbus_rd_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .byte_mode (byte_q),
        .bus_gnt   (bus_gnt),
        .xb_ready  (xb_ready),
        .idle      (idle),
        .ctl       (ctl)
    );

    xbus_rd_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .byte_mode (byte_q),
        .lane_sel  (addr_q[LB-1:0]),
        .cap_lo    (ctl.cap_lo),
        .cap_hi    (ctl.cap_hi),
        .din       (xb_din),
        .rdata     (cpu_rdata)
    );

    assign bus_req    = ctl.breq;
    assign xb_cs_n    = ~ctl.cs;
    assign xb_addr_oe = ctl.cs;
    assign xb_addr    = ctl.cs ? addr_q : '0;
    assign cpu_done   = ctl.done;

endmodule

// File: rtl/xbus_rd_seq_chk.sv
module xbus_rd_seq_chk (
    input logic clk,
    input logic rst,
    input logic cpu_done,
    input logic bus_req,
    input logic bus_gnt,
    input logic xb_cs_n,
    input logic xb_addr_oe
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (xb_cs_n && !bus_req && !cpu_done && !xb_addr_oe));

    a_r8_cs_needs_grant: assert property (@(posedge clk) disable iff (rst)
        !xb_cs_n |-> (bus_req && bus_gnt));

    a_r8_oe_only_with_cs: assert property (@(posedge clk) disable iff (rst)
        xb_addr_oe |-> !xb_cs_n);

    a_r2_cs_after_grant: assert property (@(posedge clk) disable iff (rst)
        $fell(xb_cs_n) |-> $past(bus_req && bus_gnt));

    a_r5_hold_request: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> bus_req);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    a_r9_done_releases: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> (!bus_req && xb_cs_n));

endmodule

bind xbus_rd_seq xbus_rd_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_done   (cpu_done),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .xb_cs_n    (xb_cs_n),
    .xb_addr_oe (xb_addr_oe)
);

// File: tb/sim_xbus_rd_seq.sv
`timescale 1ns/1ps
module sim_xbus_rd_seq;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_req;
    logic [AW-1:0] cpu_addr;
    logic          cpu_byte;
    logic          cpu_done;
    logic [31:0]   cpu_rdata;
    logic          bus_req;
    logic          bus_gnt;
    logic          xb_cs_n;
    logic [AW-1:0] xb_addr;
    logic          xb_addr_oe;
    logic          xb_ready;
    logic [DW-1:0] xb_din;
    logic          dma_hold;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    // model arbiter: a DMA master holding the bus blocks the grant
    assign bus_gnt = bus_req & ~dma_hold;

    xbus_rd_seq #(.AW(AW), .DW(DW)) u0 (
        .clk, .rst, .cpu_req, .cpu_addr, .cpu_byte, .cpu_done, .cpu_rdata,
        .bus_req, .bus_gnt, .xb_cs_n, .xb_addr, .xb_addr_oe, .xb_ready, .xb_din
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    // one full read, checked cycle by cycle on falling edges
    task automatic run_read(input logic [AW-1:0] a, input logic byt,
                            input int stall, input int hold,
                            input logic [15:0] d0, input logic [15:0] d1,
                            input logic early_rdy, input logic extra_req);
        logic [31:0] exp;
        int iters;
        exp = byt ? (a[0] ? {24'h0, d0[15:8]} : {24'h0, d0[7:0]}) : {d1, d0};
        cpu_req = 1'b1; cpu_addr = a; cpu_byte = byt;
        tick;
        cpu_req = 1'b0; cpu_addr = '0; cpu_byte = 1'b0;
        chk("R2 bus_req after cpu_req", {31'h0, bus_req}, 32'h1);
        tick;
        chk("R2 cs_n in address phase", {31'h0, xb_cs_n}, 32'h0);
        chk("R2 addr_oe in address phase", {31'h0, xb_addr_oe}, 32'h1);
        chk("R2 address value", {8'h0, xb_addr}, {8'h0, a});
        if (early_rdy) xb_ready = 1'b1;
        tick;
        xb_ready = 1'b0;
        chk("R3 bus_req released", {31'h0, bus_req}, 32'h0);
        chk("R3 cs_n released", {31'h0, xb_cs_n}, 32'h0 | 32'h1);
        chk("R3 addr_oe released", {31'h0, xb_addr_oe}, 32'h0);
        if (early_rdy) begin
            tick;
            chk("R4 early ready ignored", {31'h0, bus_req}, 32'h0);
        end
        for (int i = 0; i < stall; i++) begin
            if (extra_req && i == 0) begin
                cpu_req = 1'b1; cpu_addr = ~a; cpu_byte = ~byt;
            end
            tick;
            cpu_req = 1'b0;
            if (i == stall - 1 || i == 0) begin
                chk("R10 parked bus_req low", {31'h0, bus_req}, 32'h0);
                chk("R10 parked cs_n high", {31'h0, xb_cs_n}, 32'h1);
            end
        end
        dma_hold = (hold > 0);
        xb_ready = 1'b1;
        tick;
        xb_ready = 1'b0;
        iters = (hold > 0) ? hold : 1;
        for (int i = 0; i < iters; i++) begin
            chk("R5 bus_req after ready", {31'h0, bus_req}, 32'h1);
            chk("R8 cs_n high without grant", {31'h0, xb_cs_n}, 32'h1);
            chk("R8 addr_oe low without grant", {31'h0, xb_addr_oe}, 32'h0);
            if (i == iters - 1) dma_hold = 1'b0;
            tick;
        end
        xb_din = 16'hDEAD;
        chk("R6 cs_n in resume phase", {31'h0, xb_cs_n}, 32'h0);
        chk("R6 address in resume phase", {8'h0, xb_addr}, {8'h0, a});
        tick;
        xb_din = d0;
        chk("R6 cs_n in first transfer", {31'h0, xb_cs_n}, 32'h0);
        tick;
        if (!byt) begin
            xb_din = d1;
            chk("R6 no done before second half", {31'h0, cpu_done}, 32'h0);
            tick;
        end
        xb_din = 16'hBEEF;
        chk(byt ? "R7 done after byte transfer" : "R6 done after word transfer",
            {31'h0, cpu_done}, 32'h1);
        chk(byt ? "R7 byte data" : "R6 word data", cpu_rdata, exp);
        chk("R9 bus released at done", {31'h0, bus_req}, 32'h0);
        tick;
        chk("R9 done is one cycle", {31'h0, cpu_done}, 32'h0);
        chk("R9 idle, no extra request", {31'h0, bus_req}, 32'h0);
    endtask

    task automatic t_reset;
        rst = 1'b1; cpu_req = 1'b0; cpu_addr = '0; cpu_byte = 1'b0;
        xb_ready = 1'b0; xb_din = '0; dma_hold = 1'b0;
        repeat (3) tick;
        chk("R1 cs_n in reset", {31'h0, xb_cs_n}, 32'h1);
        chk("R1 bus_req in reset", {31'h0, bus_req}, 32'h0);
        chk("R1 done in reset", {31'h0, cpu_done}, 32'h0);
        chk("R1 addr_oe in reset", {31'h0, xb_addr_oe}, 32'h0);
        rst = 1'b0;
        tick;
    endtask

    task automatic t_word_plain;    run_read(24'h00_1234, 1'b0, 3, 0, 16'h5A01, 16'hC3F2, 1'b0, 1'b0); endtask
    task automatic t_word_dma;      run_read(24'h7F_0010, 1'b0, 2, 4, 16'h1111, 16'h8888, 1'b0, 1'b0); endtask
    task automatic t_byte_even;     run_read(24'h00_0100, 1'b1, 1, 0, 16'hAB34, 16'h0000, 1'b0, 1'b0); endtask
    task automatic t_byte_odd;      run_read(24'h00_0101, 1'b1, 2, 2, 16'hAB34, 16'h0000, 1'b0, 1'b0); endtask
    task automatic t_early_ready;   run_read(24'h12_3456, 1'b0, 1, 0, 16'h0F0F, 16'hF0F0, 1'b1, 1'b0); endtask
    task automatic t_busy_request;  run_read(24'h55_AA00, 1'b0, 3, 1, 16'h2468, 16'h1357, 1'b0, 1'b1); endtask
    task automatic t_long_stall;    run_read(24'hFF_FFFE, 1'b0, 500, 0, 16'hFFFF, 16'h0001, 1'b0, 1'b0); endtask

    initial begin
        t_reset;
        t_word_plain;
        t_word_dma;
        t_byte_even;
        t_byte_odd;
        t_early_ready;
        t_busy_request;
        t_long_stall;
        repeat (2) tick;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule